// File: doc/BRIEF.md
# Shared Address/Data Bus Peripheral Port

This block sits on the peripheral side of a processor bus in which the low address bits and the data bits use the same pins. Every machine cycle starts with an address phase. The processor drives the low address onto the shared lines and raises the address-latch-enable input `ale`. The upper address bits arrive on their own pins, `hiAddr`. The block keeps the full address internally and holds it after `ale` drops. This leaves the shared lines free for data.

After the address phase, an active-low read or write strobe moves one word between the processor and the block. The block contains a small bank of word-wide registers, selected by the lowest address bits. Slot 0 is a read-only status word, taken live from `statusIn`. The other slots can be read and written. The shared bus is modelled as three signals: an input copy `busIn`, a drive value `busOut`, and an output enable `busOe`. The block turns `busOe` on only during an active read to its own address window. At all other times it leaves the lines tristated.

`DATA_W` is 8 or 16. With 8, the shared lines carry address bits 7:0. With 16, they carry address bits 15:0. `ADDR_W` must be larger than `DATA_W`. The window is the `REG_CNT` addresses that start at `BASE_ADDR`, which must be aligned to `REG_CNT`. All inputs are sampled in the `clk` domain.

Top module: `mux_bus_slave`

## Requirements
- R1: After reset, every writable slot reads back as zero, and `busOe` stays low while no read strobe is active.
- R2: On each clock edge at which `ale` is high, the block loads `{hiAddr, busIn}` as the cycle address, so the last value seen with `ale` high wins. After `ale` falls, the address holds, even while the shared lines carry other values.
- R3: The low log2(`REG_CNT`) bits of the held address pick the slot (default: 0 to 3). The remaining upper bits must equal the same bits of `BASE_ADDR` (default 0x4A00, window 0x4A00 to 0x4A03).
- R4: While `rdN` is low, `ale` is low and the held address is inside the window, `busOe` is high and `busOut` equals the selected slot. Slot 0 returns the current `statusIn`.
- R5: `busOe` is low in every cycle in which `ale` is high or `rdN` is high, including a cycle where `rdN` is already low while `ale` is still high.
- R6: A write takes effect at the first clock edge at which `wrN` is seen high after being low. The value stored is the last `busIn` sampled while `wrN` was low, not the value on the lines at the release.
- R7: A write to slot 0 has no effect. Reading slot 0 still returns `statusIn`.
- R8: An address outside the window produces no bus drive on a read and no register change on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| ale | input | 1 | Address-latch enable, high during the address phase |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| hiAddr | input | ADDR_W-DATA_W | Upper address bits on dedicated pins |
| busIn | input | DATA_W | Value present on the shared address/data lines |
| busOut | output | DATA_W | Value the block drives onto the shared lines |
| busOe | output | 1 | High when the block drives the shared lines |
| statusIn | input | DATA_W | Live contents of read-only slot 0 |

## Verification
A write commit and the address latch for the following cycle can fall on the same clock edge. This happens when the processor releases `wrN` in the same cycle that it raises `ale` with a new address on the shared lines. The bench forces this case: it writes to one slot and, on the releasing edge, raises `ale` with the address of a neighbouring slot. The case passes only if the written value lands in the old slot and a read of the new slot still returns its earlier contents.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  // Strobes passed from the control module to the datapath
  typedef struct packed {
    logic latchAddr;    // load address from the shared lines
    logic captureData;  // hold the write value while the strobe is low
    logic commitWrite;  // store the held value into the selected slot
    logic driveBus;     // enable the output drivers
  } mbs_strobe_t;
endpackage

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
  import mbs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ale,
  input  logic        rdN,
  input  logic        wrN,
  input  logic        hit,
  output mbs_strobe_t strobes
);
  logic wrNPrev;

  always_ff @(posedge clk) begin
    if (!rstN) wrNPrev <= 1'b1;
    else       wrNPrev <= wrN;
  end

  always_comb begin
    strobes.latchAddr   = ale;
    strobes.captureData = ~wrN;
    strobes.commitWrite = wrN & ~wrNPrev & hit;
    strobes.driveBus    = ~rdN & ~ale & hit;
  end
endmodule

// File: rtl/mbs_dpath.sv
module mbs_dpath
  import mbs_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 16,
  parameter int REG_CNT   = 4,
  parameter int BASE_ADDR = 'h4A00
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  mbs_strobe_t                   strobes,
  input  logic [ADDR_W-DATA_W-1:0]      hiAddr,
  input  logic [DATA_W-1:0]             busIn,
  input  logic [DATA_W-1:0]             statusIn,
  output logic                          hit,
  output logic [DATA_W-1:0]             busOut,
  output logic [ADDR_W-1:0]             latchedAddr,
  output logic [(REG_CNT-1)*DATA_W-1:0] bankFlat
);
  localparam int SEL_W = $clog2(REG_CNT);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);

  logic [DATA_W-1:0] wrHold;
  logic [REG_CNT-1:0][DATA_W-1:0] readVec;
  logic [SEL_W-1:0] sel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchedAddr <= '0;
      wrHold      <= '0;
    end else begin
      if (strobes.latchAddr)   latchedAddr <= {hiAddr, busIn};
      if (strobes.captureData) wrHold      <= busIn;
    end
  end

  assign sel = latchedAddr[SEL_W-1:0];
  assign hit = (latchedAddr[ADDR_W-1:SEL_W] == BASE_V[ADDR_W-1:SEL_W]);
  assign readVec[0] = statusIn;

  for (genvar g = 1; g < REG_CNT; g++) begin : gSlot
    logic [DATA_W-1:0] slot;
    always_ff @(posedge clk) begin
      if (!rstN) slot <= '0;
      else if (strobes.commitWrite && sel == SEL_W'(g)) slot <= wrHold;
    end
    assign readVec[g] = slot;
    assign bankFlat[(g-1)*DATA_W +: DATA_W] = slot;
  end

  assign busOut = readVec[sel];
endmodule

// File: rtl/mux_bus_slave.sv
module mux_bus_slave
  import mbs_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 16,
  parameter int REG_CNT   = 4,
  parameter int BASE_ADDR = 'h4A00
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     ale,
  input  logic                     rdN,
  input  logic                     wrN,
  input  logic [ADDR_W-DATA_W-1:0] hiAddr,
  input  logic [DATA_W-1:0]        busIn,
  output logic [DATA_W-1:0]        busOut,
  output logic                     busOe,
  input  logic [DATA_W-1:0]        statusIn
);
  mbs_strobe_t strobes;
  logic hit;
  logic [ADDR_W-1:0] latchedAddr;
  logic [(REG_CNT-1)*DATA_W-1:0] bankFlat;

  mbs_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .ale(ale), .rdN(rdN), .wrN(wrN),
    .hit(hit), .strobes(strobes)
  );

  mbs_dpath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_CNT(REG_CNT), .BASE_ADDR(BASE_ADDR)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .hiAddr(hiAddr), .busIn(busIn),
    .statusIn(statusIn), .hit(hit), .busOut(busOut),
    .latchedAddr(latchedAddr), .bankFlat(bankFlat)
  );

  assign busOe = strobes.driveBus;
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 16,
  parameter int REG_CNT = 4
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          ale,
  input logic                          rdN,
  input logic                          wrN,
  input logic                          busOe,
  input logic [DATA_W-1:0]             busOut,
  input logic [DATA_W-1:0]             statusIn,
  input logic                          hit,
  input logic [ADDR_W-1:0]             latchedAddr,
  input logic [(REG_CNT-1)*DATA_W-1:0] bankFlat
);
  localparam int SEL_W = $clog2(REG_CNT);

  AST_OE_QUIET_ALE: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> !busOe); // R5
  AST_OE_QUIET_RD: assert property (@(posedge clk) disable iff (!rstN)
    rdN |-> !busOe); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ale |=> $stable(latchedAddr)); // R2
  AST_BANK_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(wrN) |=> $stable(bankFlat)); // R6
  AST_OUTSIDE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> !busOe); // R8
  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && latchedAddr[SEL_W-1:0] == '0) |-> busOut == statusIn); // R4
endmodule

bind mux_bus_slave mbs_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_CNT(REG_CNT)
) uChk (
  .clk(clk), .rstN(rstN), .ale(ale), .rdN(rdN), .wrN(wrN), .busOe(busOe),
  .busOut(busOut), .statusIn(statusIn), .hit(hit),
  .latchedAddr(latchedAddr), .bankFlat(bankFlat)
);

// File: tb/tb_mux_bus_slave.sv
module tb_mux_bus_slave;
  localparam int DW = 8;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ale = 1'b0, rdN = 1'b1, wrN = 1'b1;
  logic [AW-DW-1:0] hiAddr = '0;
  logic [DW-1:0] busIn = '0, statusIn = 8'hC3;
  logic [DW-1:0] busOut;
  logic busOe;

  always #5 clk = ~clk;

  mux_bus_slave #(.DATA_W(DW), .ADDR_W(AW), .REG_CNT(4), .BASE_ADDR('h4A00)) dut (
    .clk(clk), .rstN(rstN), .ale(ale), .rdN(rdN), .wrN(wrN), .hiAddr(hiAddr),
    .busIn(busIn), .busOut(busOut), .busOe(busOe), .statusIn(statusIn)
  );

  typedef struct {
    logic        oe;
    logic [DW-1:0] data;
    string       req;
  } item_t;

  item_t expQ[$];
  logic probe = 1'b0;
  int compared = 0, mismatched = 0;
  logic [DW-1:0] model [4];

  // Monitor: pops one expected item per probed cycle, away from the edge
  always @(negedge clk) begin
    if (probe && expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      compared++;
      if (busOe !== it.oe || (it.oe && busOut !== it.data)) begin
        mismatched++;
        $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h",
                 it.req, busOe, busOut, it.oe, it.data);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic expect_now(input logic oe, input logic [DW-1:0] d, input string req);
    item_t it;
    it.oe = oe; it.data = d; it.req = req;
    expQ.push_back(it);
    probe = 1'b1;
    tick();
    probe = 1'b0;
  endtask

  task automatic addr_phase(input logic [AW-1:0] a);
    ale = 1'b1; hiAddr = a[AW-1:DW]; busIn = a[DW-1:0];
    tick();
    ale = 1'b0; busIn = 8'hEE;
  endtask

  function automatic logic in_win(input logic [AW-1:0] a);
    return a[AW-1:2] == 14'(16'h4A00 >> 2);
  endfunction

  task automatic wr_cycle(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr_phase(a);
    wrN = 1'b0; busIn = 8'hAA;
    tick();
    busIn = d;
    tick();
    wrN = 1'b1; busIn = 8'h5A;
    tick();
    if (in_win(a) && a[1:0] != 2'd0) model[a[1:0]] = d;
  endtask

  task automatic rd_cycle(input logic [AW-1:0] a, input string req);
    addr_phase(a);
    rdN = 1'b0;
    if (!in_win(a))          expect_now(1'b0, '0, req);
    else if (a[1:0] == 2'd0) expect_now(1'b1, statusIn, req);
    else                     expect_now(1'b1, model[a[1:0]], req);
    rdN = 1'b1;
    tick();
  endtask

  initial begin
    #200000;
    mismatched++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1: idle after reset, no drive
    expect_now(1'b0, '0, "R1 idle oe");
    rd_cycle(16'h4A01, "R1 reset slot1");
    rd_cycle(16'h4A02, "R1 reset slot2");
    rd_cycle(16'h4A03, "R1 reset slot3");
    // R4: status slot returns live input
    rd_cycle(16'h4A00, "R4 status read");
    statusIn = 8'h3C;
    rd_cycle(16'h4A00, "R4 status live");
    // R6: writes commit and read back; last low value is stored
    wr_cycle(16'h4A01, 8'h11);
    wr_cycle(16'h4A02, 8'h22);
    wr_cycle(16'h4A03, 8'h33);
    rd_cycle(16'h4A01, "R6 slot1");
    rd_cycle(16'h4A02, "R6 slot2");
    rd_cycle(16'h4A03, "R6 slot3");
    // R7: slot 0 not writable
    wr_cycle(16'h4A00, 8'h99);
    rd_cycle(16'h4A00, "R7 slot0 ignores write");
    // R8: outside window, no write, no drive
    wr_cycle(16'h4B01, 8'h77);
    wr_cycle(16'h4A05, 8'h66);
    rd_cycle(16'h4A01, "R8 slot1 untouched");
    rd_cycle(16'h4B01, "R8 outside read silent");
    rd_cycle(16'h4A05, "R3 neighbour window silent");
    // R5: read strobe already low while ale high
    ale = 1'b1; hiAddr = 8'h4A; busIn = 8'h02; rdN = 1'b0;
    expect_now(1'b0, '0, "R5 oe off during ale");
    ale = 1'b0; busIn = 8'hEE;
    expect_now(1'b1, model[2], "R5 oe on after ale");
    rdN = 1'b1;
    expect_now(1'b0, '0, "R5 oe off after rd");
    // R2: last address seen with ale high wins, held after fall
    ale = 1'b1; hiAddr = 8'h4A; busIn = 8'h01;
    tick();
    busIn = 8'h03;
    tick();
    ale = 1'b0; busIn = 8'h01; rdN = 1'b0;
    expect_now(1'b1, model[3], "R2 last latched address");
    busIn = 8'h02;
    expect_now(1'b1, model[3], "R2 address holds");
    rdN = 1'b1;
    tick();
    // R6 with overlap: release wrN on the edge that latches the next address
    addr_phase(16'h4A02);
    wrN = 1'b0; busIn = 8'h5C;
    tick();
    wrN = 1'b1; ale = 1'b1; hiAddr = 8'h4A; busIn = 8'h03;
    tick();
    model[2] = 8'h5C;
    ale = 1'b0; busIn = 8'hEE; rdN = 1'b0;
    expect_now(1'b1, model[3], "R6 overlap new slot untouched");
    rdN = 1'b1;
    tick();
    rd_cycle(16'h4A02, "R6 overlap old slot written");
    // R1: reset clears again
    rstN = 1'b0;
    tick();
    rstN = 1'b1;
    for (int i = 1; i < 4; i++) model[i] = '0;
    rd_cycle(16'h4A02, "R1 cleared by reset");
    repeat (2) tick();
    if (expQ.size() != 0) begin
      mismatched++;
      $display("FAIL R1: %0d unconsumed items, expected 0", expQ.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule